// File: doc/BRIEF.md
# RAM Wavetable Direct Digital Synthesizer

This block synthesizes a periodic waveform for a sample-driven DAC. A free-running down-counter divides the system clock and produces a single-cycle update tick. On each tick a phase accumulator advances by a registered frequency word, and the accumulator value plus a phase offset selects an entry of a writable wavetable. One waveform period occupies the whole table, which holds 1024 entries by default.

The selected entry is treated as a signed two's-complement sample and multiplied by an unsigned amplitude scale. The upper half of the product goes to a registered DAC data port, together with a one-cycle valid strobe. The host can rewrite table entries at any time, and it can move the frequency word, the phase offset and the amplitude at run time for frequency, phase and amplitude modulation.

The output side is a push-only stream with no back-pressure. `dac_valid` is high for one cycle per sample, the DAC must accept every strobe, and `dac_data` holds its value between strobes.

Top module: `wt_synth`

## Requirements
- R1: Outside reset the update tick occurs once every 2^DIV_W clock cycles. The first tick falls in the cycle that follows the first rising edge at which `rst` is sampled low.
- R2: On each tick, the value on `fcw` is captured into an internal register. On the same tick the accumulator adds the previously captured value, so a change on `fcw` reaches the accumulator one tick later. Reset clears both registers to zero.
- R3: The accumulator counts modulo 2^PHASE_W and wraps silently. A step of 2^PHASE_W minus k walks the table backwards.
- R4: The table address read on a tick is bits [PHASE_W-1 : PHASE_W-ADDR_W] of (accumulator + `phase_off`) modulo 2^PHASE_W. The accumulator value used is the one before that tick's update, and `phase_off` is sampled in the tick cycle. The offset never changes the accumulator.
- R5: When `wr_en` is high at a rising edge, `wr_data` is written to entry `wr_addr`. This also happens while `rst` is high. If a tick reads the same entry at the same edge, the tick returns the old content.
- R6: The output sample equals floor(entry × `amp` / 2^DATA_W), where the entry is read as signed and `amp` as unsigned. `amp` is sampled in the cycle after the tick. An `amp` of zero gives a zero sample.
- R7: If the tick is high in cycle T, `dac_valid` is high in cycle T+2 with the new `dac_data`. `dac_valid` is low in every other cycle.
- R8: While `dac_valid` is low, `dac_data` keeps its last value.
- R9: A synchronous active-high `rst` clears the divider, the accumulator, the frequency register, `dac_valid` and `dac_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fcw | input | PHASE_W | Frequency control word, captured on each tick |
| phase_off | input | PHASE_W | Phase offset added before address selection |
| amp | input | DATA_W | Unsigned amplitude scale |
| wr_en | input | 1 | Table write enable |
| wr_addr | input | ADDR_W | Table write address |
| wr_data | input | DATA_W | Table write data |
| dac_data | output | DATA_W | Scaled signed sample for the DAC |
| dac_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The bench builds the block with PHASE_W=12, ADDR_W=4, DATA_W=8 and DIV_W=2. With these values the table has 16 entries, a tick comes every four cycles, and the phase word spans only 4096 values. A run of a few dozen ticks therefore visits every table entry, crosses the accumulator wrap in both directions, and reaches both ends of the signed sample range and of the amplitude range. Every sample is predicted arithmetically from the captured frequency word, the offset and the amplitude. The frequency and offset switch mid-run, and a write is aimed at the entry being read in a tick cycle.

// File: rtl/wt_synth_pkg.sv
package wt_synth_pkg;
  // Default geometry of the synthesizer
  localparam int PHASE_W_DEF = 32;
  localparam int ADDR_W_DEF  = 10;
  localparam int DATA_W_DEF  = 24;
  localparam int DIV_W_DEF   = 16;
endpackage

// File: rtl/wt_div.sv
module wt_div #(
  parameter int DIV_W = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int MSB = DIV_W - 1;

  logic [DIV_W-1:0] cnt_q;
  logic             msb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      msb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
      msb_q <= cnt_q[MSB];
    end
  end

  // single-cycle enable on the rising transition of the counter MSB
  assign tick = cnt_q[MSB] & ~msb_q;
endmodule

// File: rtl/wt_phase.sv
module wt_phase #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [PHASE_W-1:0] fcw,
  input  logic [PHASE_W-1:0] phase_off,
  output logic [ADDR_W-1:0]  rd_addr
);
  localparam int FRAC_W = PHASE_W - ADDR_W;

  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] fcw_q;
  logic [PHASE_W-1:0] sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      fcw_q <= '0;
    end else if (tick) begin
      acc_q <= acc_q + fcw_q;
      fcw_q <= fcw;
    end
  end

  assign sum     = acc_q + phase_off;
  assign rd_addr = ADDR_W'(sum >> FRAC_W);
endmodule

// File: rtl/wt_table.sv
module wt_table #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // read-before-write: a same-edge collision returns the old word
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_en;
  end
endmodule

// File: rtl/wt_scale.sv
module wt_scale #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] amp,
  output logic [DATA_W-1:0] dac_data,
  output logic              dac_valid
);
  localparam int PROD_W = 2 * DATA_W + 1;

  logic signed [PROD_W-1:0] s_ext;
  logic signed [PROD_W-1:0] a_ext;
  logic signed [PROD_W-1:0] prod;

  assign s_ext = {{(DATA_W + 1){sample[DATA_W-1]}}, sample};
  assign a_ext = {{(DATA_W + 1){1'b0}}, amp};
  assign prod  = s_ext * a_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_data  <= '0;
      dac_valid <= 1'b0;
    end else begin
      dac_valid <= in_valid;
      if (in_valid) dac_data <= DATA_W'(prod >>> DATA_W);
    end
  end
endmodule

// File: rtl/wt_synth.sv
module wt_synth
  import wt_synth_pkg::*;
#(
  parameter int PHASE_W = PHASE_W_DEF,
  parameter int ADDR_W  = ADDR_W_DEF,
  parameter int DATA_W  = DATA_W_DEF,
  parameter int DIV_W   = DIV_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] fcw,
  input  logic [PHASE_W-1:0] phase_off,
  input  logic [DATA_W-1:0]  amp,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  dac_data,
  output logic               dac_valid
);
  logic              tick;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid;

  wt_div #(.DIV_W(DIV_W)) div_i (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  wt_phase #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) phase_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .fcw      (fcw),
    .phase_off(phase_off),
    .rd_addr  (rd_addr)
  );

  wt_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) table_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (tick),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .rd_valid(rd_valid)
  );

  wt_scale #(.DATA_W(DATA_W)) scale_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (rd_valid),
    .sample   (rd_data),
    .amp      (amp),
    .dac_data (dac_data),
    .dac_valid(dac_valid)
  );
endmodule

// File: rtl/wt_synth_chk.sv
module wt_synth_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [DATA_W-1:0] amp,
  input logic [DATA_W-1:0] dac_data,
  input logic              dac_valid
);
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (!dac_valid && dac_data == '0));

  assert_tick_single_R1: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  assert_valid_after_tick_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(tick, 2) && !$past(rst) && !$past(rst, 2)) |-> dac_valid);

  assert_valid_needs_tick_R7: assert property (@(posedge clk) disable iff (rst)
    dac_valid |-> $past(tick, 2));

  assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
    (!dac_valid && !$past(rst)) |-> $stable(dac_data));

  assert_zero_amp_R6: assert property (@(posedge clk) disable iff (rst)
    (dac_valid && $past(amp) == '0 && !$past(rst)) |-> dac_data == '0);
endmodule

bind wt_synth wt_synth_chk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .amp      (amp),
  .dac_data (dac_data),
  .dac_valid(dac_valid)
);

// File: tb/wt_synth_tb_top.sv
module wt_synth_tb_top;
  localparam int PW = 12;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DV = 2;
  localparam int PER = 1 << DV;
  localparam int N_ENT = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PW-1:0] fcw = '0;
  logic [PW-1:0] phase_off = '0;
  logic [DW-1:0] amp = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] dac_data;
  logic          dac_valid;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;
  int tab [N_ENT];

  always #2.5 clk = ~clk;

  wt_synth #(.PHASE_W(PW), .ADDR_W(AW), .DATA_W(DW), .DIV_W(DV)) dut_i (
    .clk(clk), .rst(rst), .fcw(fcw), .phase_off(phase_off), .amp(amp),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dac_data(dac_data), .dac_valid(dac_valid)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one scenario: reset, table load during reset, then ncyc cycles of running
  task automatic run(string tag, int ncyc, int fa, int fb, int oa, int ob,
                     int sw, int amp_v, int col, int col_val);
    int acc = 0;
    int freg = 0;
    int pend = 0;
    int last = 0;
    int c = 0;
    @(negedge clk);
    rst = 1'b1; fcw = PW'(fa); phase_off = PW'(oa); amp = DW'(amp_v);
    for (int i = 0; i < N_ENT; i++) begin
      tab[i] = ((i * 53 + 17) % 256) - 128;
      if (i == 3) tab[i] = -128;
      if (i == 7) tab[i] = 127;
      wr_en = 1'b1; wr_addr = AW'(i); wr_data = DW'(tab[i]);
      @(negedge clk);
    end
    wr_en = 1'b0;
    @(negedge clk);
    check(dac_valid == 1'b0, "R9 reset valid", int'(dac_valid), 0);
    check(dac_data == '0, "R9 reset data", int'(dac_data), 0);
    rst = 1'b0;
    for (int k = 0; k < ncyc; k++) begin
      int off_c;
      @(posedge clk);
      c++;
      @(negedge clk);
      if (c % PER == 3) begin
        check(dac_valid == 1'b1, "R7 strobe", int'(dac_valid), 1);
        check(int'($signed(dac_data)) == pend, tag, int'($signed(dac_data)), pend);
        last = pend;
      end else begin
        check(dac_valid == 1'b0, "R1 tick spacing", int'(dac_valid), 0);
        check(int'($signed(dac_data)) == last, "R8 hold", int'($signed(dac_data)), last);
      end
      fcw = PW'((c >= sw) ? fb : fa);
      off_c = (c >= sw) ? ob : oa;
      phase_off = PW'(off_c);
      wr_en = 1'b0;
      if (c % PER == 1) begin
        int a;
        a = ((acc + off_c) % (1 << PW)) >> (PW - AW);
        pend = (tab[a] * amp_v) >>> DW;
        acc = (acc + freg) % (1 << PW);
        freg = (c >= sw) ? fb : fa;
        if (col >= 0 && c == 13) begin
          wr_en = 1'b1; wr_addr = AW'(col); wr_data = DW'(col_val);
          tab[col] = col_val;
        end
      end
    end
    wr_en = 1'b0;
  endtask

  initial begin
    run("R4 unit step", 80, 'h100, 'h100, 0, 0, 1000, 255, -1, 0);
    run("R4 fractional step", 120, 'h0A7, 'h0A7, 'h0F3, 'h0F3, 1000, 200, -1, 0);
    run("R3 backward wrap", 80, 'hF00, 'hF00, 'h800, 'h800, 1000, 128, -1, 0);
    run("R2 freq and offset switch", 100, 'h100, 'h300, 0, 'h400, 22, 255, -1, 0);
    run("R6 zero amplitude", 40, 'h130, 'h130, 0, 0, 1000, 0, -1, 0);
    run("R5 collision read old", 40, 0, 0, 'h500, 'h500, 1000, 255, 5, -99);
    run("R3 near-full step", 100, 'hFFF, 'hFFF, 'hFFF, 'hFFF, 1000, 255, -1, 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule